// File: doc/BRIEF.md
# Single-frame PIO Ethernet mailbox

This block sits between a host processor and a small management Ethernet MAC that has no DMA. The host moves every frame itself, one 32-bit word at a time, through two data ports. Each direction owns exactly one frame buffer. A control word per direction acts as the ownership token: the host sets the transmit busy bit to hand a frame to the MAC side, and the block clears it when the last byte has left. The block sets the receive ready bit when a frame has landed, and the host clears it to give the buffer back.

On the MAC side, bytes leave on a valid/ready byte stream that carries a last marker. A fail input reports a failed send. Bytes arrive on a valid byte stream that carries last, error and CRC-error markers. Two interrupt causes, transmit done and receive ready, are each gated by an enable bit. The gated causes are combined onto one interrupt line. A frame that arrives while the host still owns the receive buffer is thrown away and counted.

Top module: `pio_eth_mailbox`

## Requirements
- R1: After reset, the transmit control, receive control, interrupt enable and interrupt cause registers all read zero, `irq` is low, `mac_tx_valid` is low and `rx_drop_count` is zero.
- R2: Words written to offset 0x808, followed by a write to 0x800 with bit 16 set and the byte count in bits [10:0], make the block emit exactly that many bytes on the transmit stream. Bytes go out big-endian: byte 0 is bits [31:24] of the first word. `mac_tx_last` is high on the final byte only. Padding bytes in the last word are not sent.
- R3: While `mac_tx_valid` is high and `mac_tx_ready` is low, the byte and last marker on the transmit stream hold steady.
- R4: Transmit control (0x800) reads bit 16 = 1 from the start until the final byte is accepted, then reads 0. Bits [10:0] keep the byte count. Bit 17 reads the value of `mac_tx_fail` sampled with the final byte.
- R5: While bit 16 of transmit control is set, writes to 0x800 and 0x808 are ignored, so the frame in flight and its length are unchanged.
- R6: When a received byte with `mac_rx_last` is taken, receive control (0x810) reads bit 16 = 1 and bits [10:0] = the frame's byte count. Bit 17 reads `mac_rx_err` and bit 18 reads `mac_rx_crc_err`, both sampled with the last byte.
- R7: Each read of 0x818 returns the next buffered word and advances by one. Words are big-endian, and unused bytes of the final word read as zero. A read when the frame's ceil(len/4) words are exhausted, or when no frame is ready, returns zero and changes nothing.
- R8: A write to 0x810 with bit 16 clear hands the receive buffer back: bit 16 reads 0, the word pointer restarts, and the next arriving frame is stored.
- R9: A frame that begins while receive control bit 16 is set is discarded in full. Buffer contents and receive control are unchanged, and `rx_drop_count` increases by one for each such frame.
- R10: Interrupt cause (0x8C4) bit 0 is set when a send completes and is cleared by the next write to 0x800. Bit 1 follows receive control bit 16. Interrupt enable (0x8C0) uses the same bit positions. `irq` is high exactly when some cause bit and its enable bit are both set, and writing zero to 0x8C0 masks both causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| irq | output | 1 | Combined, enabled interrupt |
| mac_tx_data | output | 8 | Transmit byte |
| mac_tx_valid | output | 1 | Transmit byte valid |
| mac_tx_last | output | 1 | Final byte of the frame |
| mac_tx_ready | input | 1 | MAC accepts the byte |
| mac_tx_fail | input | 1 | Send failed; sampled with the final byte |
| mac_rx_data | input | 8 | Received byte |
| mac_rx_valid | input | 1 | Received byte valid |
| mac_rx_last | input | 1 | Final received byte |
| mac_rx_err | input | 1 | Frame error, sampled with the last byte |
| mac_rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| rx_drop_count | output | 16 | Frames dropped because the buffer was held |

## Verification
A stale transmit word pointer or byte index shows up on the transmit stream. The first wrong or missing byte appears within one accepted byte of the fault, and a wrong `mac_tx_last` position shows at the end of the frame. A fault in the receive path (byte lane, read pointer or ownership flag) shows at the next read of 0x818 or 0x810. A wrong receive pointer or buffer lane appears as a shifted or wrongly zeroed word. A wrong ownership flag appears as a missing or extra drop-count step when the next frame arrives. Interrupt faults show on `irq` in the cycle after the cause or enable register changes.

// File: rtl/pem_pkg.sv
// Package: shared constants for the PIO Ethernet mailbox.
// Holds register offsets, control-word bit positions and the
// length field width. Assumes a 12-bit byte address on the host bus.
package pem_pkg;
    localparam int ADDR_W  = 12;
    localparam int LEN_W   = 11;
    localparam int BIT_OWN = 16;   // busy / ready ownership bit
    localparam int BIT_ERR = 17;   // error flag
    localparam int BIT_CRC = 18;   // receive CRC error flag
    localparam int IRQ_TX  = 0;
    localparam int IRQ_RX  = 1;

    localparam logic [ADDR_W-1:0] OFF_TX_CTL  = 12'h800;
    localparam logic [ADDR_W-1:0] OFF_TX_DATA = 12'h808;
    localparam logic [ADDR_W-1:0] OFF_RX_CTL  = 12'h810;
    localparam logic [ADDR_W-1:0] OFF_RX_DATA = 12'h818;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN  = 12'h8C0;
    localparam logic [ADDR_W-1:0] OFF_IRQ_CS  = 12'h8C4;
endpackage

// File: rtl/pem_tx.sv
// Module: pem_tx
// Transmit half of the mailbox. It holds one frame written by the host
// as words, then streams it out byte by byte, big-endian, once started.
// Assumes BUF_WORDS*4 >= 2**LEN_W, so any legal length fits.
module pem_tx
    import pem_pkg::*;
#(
    parameter int BUF_WORDS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [31:0]      data_in,
    input  logic             ctl_wr,
    input  logic [LEN_W-1:0] ctl_len,
    input  logic             ctl_start,
    input  logic             tx_ready,
    input  logic             tx_fail,
    output logic             busy,
    output logic             fail_flag,
    output logic [LEN_W-1:0] len,
    output logic             done_flag,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last
);
    localparam int IDX_W = $clog2(BUF_WORDS);

    logic [31:0]      mem [BUF_WORDS];
    logic [IDX_W:0]   wptr;
    logic [LEN_W-1:0] idx;
    logic [31:0]      cur_word;
    logic             wr_ok;
    logic             finish;

    assign wr_ok    = data_wr && !busy && (wptr < (IDX_W+1)'(BUF_WORDS));
    assign cur_word = mem[IDX_W'(idx >> 2)];
    assign tx_valid = busy && (idx < len);
    assign tx_last  = tx_valid && (idx == LEN_W'(len - 1'b1));
    assign finish   = busy && ((len == '0) || (tx_valid && tx_ready && tx_last));

    // Purpose: pick the outgoing byte lane, most significant byte first.
    always_comb begin
        case (idx[1:0])
            2'd0:    tx_data = cur_word[31:24];
            2'd1:    tx_data = cur_word[23:16];
            2'd2:    tx_data = cur_word[15:8];
            default: tx_data = cur_word[7:0];
        endcase
    end

    // Purpose: store host words into the frame buffer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr[IDX_W-1:0]] <= data_in;
    end

    // Purpose: ownership, byte index and completion state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            fail_flag <= 1'b0;
            len       <= '0;
            idx       <= '0;
            done_flag <= 1'b0;
            wptr      <= '0;
        end else if (!busy) begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (ctl_wr) begin
                done_flag <= 1'b0;
                len       <= ctl_len;
                if (ctl_start) begin
                    busy      <= 1'b1;
                    fail_flag <= 1'b0;
                    idx       <= '0;
                    wptr      <= '0;
                end
            end
        end else begin
            if (tx_valid && tx_ready) idx <= idx + 1'b1;
            if (finish) begin
                busy      <= 1'b0;
                done_flag <= 1'b1;
                fail_flag <= (len != '0) && tx_fail;
            end
        end
    end

    // R3: a stalled byte must not change.
    assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4: ownership returns to the host together with the done flag.
    assert_done_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);
endmodule

// File: rtl/pem_rx.sv
// Module: pem_rx
// Receive half of the mailbox. It packs incoming bytes big-endian into
// one frame buffer, hands it to the host and serves word pops. Frames
// that start while the host holds the buffer are dropped and counted.
// Assumes BUF_WORDS*4 >= 2**LEN_W; longer frames saturate the count.
module pem_rx
    import pem_pkg::*;
#(
    parameter int BUF_WORDS = 512,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    input  logic              rx_crc_err,
    input  logic              release_en,
    input  logic              pop_en,
    output logic              ready,
    output logic [LEN_W-1:0]  len,
    output logic              err_flag,
    output logic              crc_flag,
    output logic [31:0]       rd_word,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int IDX_W = $clog2(BUF_WORDS);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [31:0]      mem [BUF_WORDS];
    logic [LEN_W-1:0] cnt;
    logic             mid;
    logic             dropping;
    logic [LEN_W-2:0] rptr;
    logic [LEN_W:0]   len_p3;
    logic [LEN_W-2:0] nwords;
    logic             accept;
    logic             discard;
    logic             store;
    logic             have_word;

    assign accept    = rx_valid && !dropping && (mid || !ready);
    assign discard   = rx_valid && !accept;
    assign store     = accept && (cnt != LEN_MAX);
    assign len_p3    = {1'b0, len} + 3'd3;
    assign nwords    = len_p3[LEN_W:2];
    assign have_word = ready && (rptr < nwords);
    assign rd_word   = have_word ? mem[IDX_W'(rptr)] : 32'h0;

    // Purpose: place a byte in its lane; a new word starts with zeros.
    always_ff @(posedge clk) begin
        if (store) begin
            case (cnt[1:0])
                2'd0:    mem[IDX_W'(cnt >> 2)]        <= {rx_data, 24'h0};
                2'd1:    mem[IDX_W'(cnt >> 2)][23:16] <= rx_data;
                2'd2:    mem[IDX_W'(cnt >> 2)][15:8]  <= rx_data;
                default: mem[IDX_W'(cnt >> 2)][7:0]   <= rx_data;
            endcase
        end
    end

    // Purpose: frame assembly, ownership, drop tracking and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            len      <= '0;
            err_flag <= 1'b0;
            crc_flag <= 1'b0;
            cnt      <= '0;
            mid      <= 1'b0;
            dropping <= 1'b0;
            rptr     <= '0;
            drop_cnt <= '0;
        end else begin
            if (accept) begin
                if (rx_last) begin
                    ready    <= 1'b1;
                    len      <= store ? cnt + 1'b1 : cnt;
                    err_flag <= rx_err;
                    crc_flag <= rx_crc_err;
                    cnt      <= '0;
                    mid      <= 1'b0;
                    rptr     <= '0;
                end else begin
                    mid <= 1'b1;
                    if (store) cnt <= cnt + 1'b1;
                end
            end
            if (discard) begin
                if (rx_last) begin
                    dropping <= 1'b0;
                    if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
                end else begin
                    dropping <= 1'b1;
                end
            end
            if (release_en && ready) begin
                ready <= 1'b0;
                rptr  <= '0;
            end else if (pop_en && have_word) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    // R6: the ready bit only rises on the last byte of a frame.
    assert_ready_from_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rx_valid && rx_last));

    // R9: the drop counter never moves by more than one.
    assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R9: a held buffer keeps its length and flags.
    assert_held_frame_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready) && ready) |-> ($stable(len) && $stable(err_flag) && $stable(crc_flag)));
endmodule

// File: rtl/pio_eth_mailbox.sv
// Module: pio_eth_mailbox
// Top of the mailbox. It decodes the host register bus, instantiates
// the transmit and receive halves, and holds the interrupt enables.
// Assumes single-cycle bus accesses; a read pops the receive data port
// at the clock edge that ends the access.
module pio_eth_mailbox
    import pem_pkg::*;
#(
    parameter int BUF_WORDS = 512,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [7:0]        mac_tx_data,
    output logic              mac_tx_valid,
    output logic              mac_tx_last,
    input  logic              mac_tx_ready,
    input  logic              mac_tx_fail,
    input  logic [7:0]        mac_rx_data,
    input  logic              mac_rx_valid,
    input  logic              mac_rx_last,
    input  logic              mac_rx_err,
    input  logic              mac_rx_crc_err,
    output logic [DROP_W-1:0] rx_drop_count
);
    logic             wr_acc, rd_acc;
    logic             tx_busy, tx_fail_q, tx_done;
    logic [LEN_W-1:0] tx_len;
    logic             rx_ready, rx_err_q, rx_crc_q;
    logic [LEN_W-1:0] rx_len;
    logic [31:0]      rx_word;
    logic [1:0]       irq_en;
    logic [1:0]       cause;
    logic             unused_wdata_bits;

    assign wr_acc = bus_sel && bus_we;
    assign rd_acc = bus_sel && !bus_we;
    assign unused_wdata_bits = ^{bus_wdata[31:17], bus_wdata[15:11]};

    pem_tx #(.BUF_WORDS(BUF_WORDS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (wr_acc && bus_addr == OFF_TX_DATA),
        .data_in   (bus_wdata),
        .ctl_wr    (wr_acc && bus_addr == OFF_TX_CTL),
        .ctl_len   (bus_wdata[LEN_W-1:0]),
        .ctl_start (bus_wdata[BIT_OWN]),
        .tx_ready  (mac_tx_ready),
        .tx_fail   (mac_tx_fail),
        .busy      (tx_busy),
        .fail_flag (tx_fail_q),
        .len       (tx_len),
        .done_flag (tx_done),
        .tx_valid  (mac_tx_valid),
        .tx_data   (mac_tx_data),
        .tx_last   (mac_tx_last)
    );

    pem_rx #(.BUF_WORDS(BUF_WORDS), .DROP_W(DROP_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (mac_rx_valid),
        .rx_data    (mac_rx_data),
        .rx_last    (mac_rx_last),
        .rx_err     (mac_rx_err),
        .rx_crc_err (mac_rx_crc_err),
        .release_en (wr_acc && bus_addr == OFF_RX_CTL && !bus_wdata[BIT_OWN]),
        .pop_en     (rd_acc && bus_addr == OFF_RX_DATA),
        .ready      (rx_ready),
        .len        (rx_len),
        .err_flag   (rx_err_q),
        .crc_flag   (rx_crc_q),
        .rd_word    (rx_word),
        .drop_cnt   (rx_drop_count)
    );

    // Purpose: interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              irq_en <= 2'b00;
        else if (wr_acc && bus_addr == OFF_IRQ_EN) irq_en <= bus_wdata[1:0];
    end

    always_comb begin
        cause         = 2'b00;
        cause[IRQ_TX] = tx_done;
        cause[IRQ_RX] = rx_ready;
    end
    assign irq = |(cause & irq_en);

    // Purpose: read data multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_TX_CTL:  bus_rdata = {13'h0, 1'b0, tx_fail_q, tx_busy, 5'h0, tx_len};
            OFF_RX_CTL:  bus_rdata = {13'h0, rx_crc_q, rx_err_q, rx_ready, 5'h0, rx_len};
            OFF_RX_DATA: bus_rdata = rx_word;
            OFF_IRQ_EN:  bus_rdata = {30'h0, irq_en};
            OFF_IRQ_CS:  bus_rdata = {30'h0, cause};
            default:     bus_rdata = 32'h0;
        endcase
    end

    // R10: the line only rises after a cause or an enable changes.
    assert_irq_has_reason_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((cause != $past(cause)) ||
                        $past(wr_acc && bus_addr == OFF_IRQ_EN)));

    // R7: with no frame held, the data port reads zero.
    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr == OFF_RX_DATA && !rx_ready) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/pio_eth_mailbox_tb_top.sv
`timescale 1ns/1ps
module pio_eth_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  mac_tx_data;
    logic        mac_tx_valid, mac_tx_last;
    logic        mac_tx_ready = 1'b0, mac_tx_fail = 1'b0;
    logic [7:0]  mac_rx_data = '0;
    logic        mac_rx_valid = 1'b0, mac_rx_last = 1'b0;
    logic        mac_rx_err = 1'b0, mac_rx_crc_err = 1'b0;
    logic [15:0] rx_drop_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    pio_eth_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .mac_tx_data(mac_tx_data), .mac_tx_valid(mac_tx_valid),
        .mac_tx_last(mac_tx_last), .mac_tx_ready(mac_tx_ready),
        .mac_tx_fail(mac_tx_fail), .mac_rx_data(mac_rx_data),
        .mac_rx_valid(mac_rx_valid), .mac_rx_last(mac_rx_last),
        .mac_rx_err(mac_rx_err), .mac_rx_crc_err(mac_rx_crc_err),
        .rx_drop_count(rx_drop_count)
    );

    // Vector fields: [10:0] length, [23:16] seed, [24] tx fail,
    // [25] tx stall, [26] rx error, [27] rx crc error.
    localparam int NV = 4;
    localparam logic [31:0] VEC [NV] = '{
        32'h0010_0040, 32'h07A0_0005, 32'h0A3C_0001, 32'h0C77_0082
    };

    function automatic logic [7:0] bexp(input logic [7:0] seed, input int i);
        return 8'(seed + i * 3);
    endfunction

    function automatic logic [31:0] wexp(input logic [7:0] seed, input int k,
                                         input int len, input logic [7:0] pad);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++)
            w = {w[23:0], ((4*k + j) < len) ? bexp(seed, 4*k + j) : pad};
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Load a frame (padding bytes 0xEE must be ignored) and start it.
    task automatic tx_load(input int len, input logic [7:0] seed);
        for (int k = 0; k < (len + 3) / 4; k++)
            bus_write(12'h808, wexp(seed, k, len, 8'hEE));
        bus_write(12'h800, 32'h0001_0000 | len);
    endtask

    task automatic tx_collect(input int len, input logic [7:0] seed, input bit stall,
                              input bit fail, output int bad, output int lastbad,
                              output int stallbad);
        int got = 0;
        int cyc = 0;
        bit held = 0;
        logic [7:0] hd = '0;
        bad = 0; lastbad = 0; stallbad = 0;
        mac_tx_fail = fail;
        while (got < len && cyc < 5000) begin
            @(negedge clk);
            mac_tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
            #1;
            if (held && (!mac_tx_valid || mac_tx_data != hd)) stallbad++;
            held = 0;
            if (mac_tx_valid) begin
                if (mac_tx_ready) begin
                    if (mac_tx_data != bexp(seed, got)) bad++;
                    if (mac_tx_last != (got == len - 1)) lastbad++;
                    got++;
                end else begin
                    held = 1; hd = mac_tx_data;
                end
            end
            cyc++;
        end
        if (got != len) bad++;
        @(negedge clk);
        mac_tx_ready = 0;
    endtask

    task automatic rx_send(input int len, input logic [7:0] seed, input bit e, input bit c);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mac_rx_valid = 1; mac_rx_data = bexp(seed, i);
            mac_rx_last = (i == len - 1);
            mac_rx_err = (i == len - 1) && e;
            mac_rx_crc_err = (i == len - 1) && c;
        end
        @(negedge clk);
        mac_rx_valid = 0; mac_rx_last = 0; mac_rx_err = 0; mac_rx_crc_err = 0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        int bad, lastbad, stallbad, wbad;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bus_read(12'h800, d); check(d == 0, "R1 tx ctl", d, 0);
        bus_read(12'h810, d); check(d == 0, "R1 rx ctl", d, 0);
        bus_read(12'h8C0, d); check(d == 0, "R1 irq en", d, 0);
        bus_read(12'h8C4, d); check(d == 0, "R1 cause", d, 0);
        check(irq == 0, "R1 irq", 32'(irq), 0);
        check(mac_tx_valid == 0, "R1 tx valid", 32'(mac_tx_valid), 0);
        check(rx_drop_count == 0, "R1 drops", 32'(rx_drop_count), 0);
        // R7: read with no frame
        bus_read(12'h818, d); check(d == 0, "R7 empty read", d, 0);

        // Vector table walk: each entry exercises both directions.
        for (int v = 0; v < NV; v++) begin
            int         len  = int'(VEC[v][10:0]);
            logic [7:0] seed = VEC[v][23:16];
            bit tf = VEC[v][24], st = VEC[v][25], re = VEC[v][26], rc = VEC[v][27];
            tx_load(len, seed);
            tx_collect(len, seed, st, tf, bad, lastbad, stallbad);
            check(bad == 0, "R2 tx bytes", 32'(bad), 0);
            check(lastbad == 0, "R2 tx last", 32'(lastbad), 0);
            check(stallbad == 0, "R3 stall hold", 32'(stallbad), 0);
            bus_read(12'h800, d);
            check(d == ({14'h0, tf, 1'b0, 5'h0, 11'(len)}), "R4 tx ctl done", d,
                  {14'h0, tf, 1'b0, 5'h0, 11'(len)});
            bus_read(12'h8C4, d); check(d[0] == 1, "R10 tx cause", d, 1);

            rx_send(len, seed, re, rc);
            bus_read(12'h810, d);
            check(d == {13'h0, rc, re, 1'b1, 5'h0, 11'(len)}, "R6 rx ctl", d,
                  {13'h0, rc, re, 1'b1, 5'h0, 11'(len)});
            wbad = 0;
            for (int k = 0; k < (len + 3) / 4; k++) begin
                bus_read(12'h818, d);
                if (d != wexp(seed, k, len, 8'h00)) begin
                    wbad++;
                    $display("FAIL R7 word %0d actual=%h expected=%h", k, d,
                             wexp(seed, k, len, 8'h00));
                end
            end
            check(wbad == 0, "R7 rx words", 32'(wbad), 0);
            bus_read(12'h818, d); check(d == 0, "R7 read past end", d, 0);
            bus_write(12'h810, 0);
            bus_read(12'h810, d); check(d[16] == 0, "R8 released", d, 0);
            bus_read(12'h8C4, d); check(d[1] == 0, "R10 rx cause clear", d, 0);
        end

        // R5: writes while busy are ignored
        tx_load(6, 8'h21);
        bus_write(12'h808, 32'hFFFF_FFFF);
        bus_write(12'h800, 32'h0001_0003);
        bus_read(12'h800, d);
        check(d == 32'h0001_0006, "R5 ctl unchanged", d, 32'h0001_0006);
        tx_collect(6, 8'h21, 0, 0, bad, lastbad, stallbad);
        check(bad == 0 && lastbad == 0, "R5 frame intact", 32'(bad + lastbad), 0);

        // R9: frame arriving while the host owns the buffer
        rx_send(7, 8'h50, 0, 0);
        rx_send(9, 8'h90, 1, 1);
        check(rx_drop_count == 1, "R9 drop count", 32'(rx_drop_count), 1);
        bus_read(12'h810, d);
        check(d == 32'h0001_0007, "R9 rx ctl kept", d, 32'h0001_0007);
        bus_read(12'h818, d);
        check(d == wexp(8'h50, 0, 7, 8'h00), "R9 word0 kept", d, wexp(8'h50, 0, 7, 8'h00));
        bus_read(12'h818, d);
        check(d == wexp(8'h50, 1, 7, 8'h00), "R9 word1 kept", d, wexp(8'h50, 1, 7, 8'h00));
        bus_read(12'h818, d); check(d == 0, "R7 exhausted", d, 0);
        bus_read(12'h810, d); check(d == 32'h0001_0007, "R7 no side effect", d, 32'h0001_0007);

        // R10: interrupt gating (rx ready and tx done both pending)
        bus_write(12'h8C0, 32'h2);
        #1 check(irq == 1, "R10 rx irq", 32'(irq), 1);
        bus_write(12'h8C0, 32'h0);
        #1 check(irq == 0, "R10 masked", 32'(irq), 0);
        bus_write(12'h8C0, 32'h1);
        #1 check(irq == 1, "R10 tx irq", 32'(irq), 1);
        bus_write(12'h800, 32'h0);
        #1 check(irq == 0, "R10 tx ack", 32'(irq), 0);
        bus_read(12'h8C4, d); check(d == 32'h2, "R10 cause", d, 32'h2);

        // R8: release, then a new frame is stored
        bus_write(12'h810, 0);
        rx_send(4, 8'hC0, 0, 0);
        bus_read(12'h810, d);
        check(d == 32'h0001_0004, "R8 next frame", d, 32'h0001_0004);
        bus_read(12'h818, d);
        check(d == wexp(8'hC0, 0, 4, 8'h00), "R8 next word", d, wexp(8'hC0, 0, 4, 8'h00));

        done = 1;
        summary();
    end
endmodule